// File: doc/BRIEF.md
# Handshaked Byte-Serial Command Framer

This block is the device-side protocol engine of a byte-at-a-time command link. A host moves one byte per transaction. It pulls an active-low request line, waits for the engine to pull the active-low acknowledge line, and then releases request. A direction flag tells which way the current byte travels. The engine takes a command code, then an optional argument count, then the argument bytes, and stores the arguments in a small buffer. It then starts an external command handler and streams that handler's response back to the host. Depending on the command, the response may be preceded by a size byte.

Each command code has an entry in a built-in length table. An entry gives the argument length and the response length, and either length may be marked variable. The entry also says whether an external handler exists. A command without a handler is answered by the engine itself: a fixed-length response becomes a run of zero bytes, and a variable-length response becomes a lone size byte of zero. The handler reads arguments through a read port and writes response bytes through a write port. It reports completion with a pulse that carries the response size.

Top module: `cmd_link_framer`

## Requirements
- R1: After reset, ack_n is 1 and byte_done, dir_err and disp_start are 0. The engine waits for a command code.
- R2: When req_n is high while ack_n is low, ack_n returns high on the next clock edge. No byte is moved and no strobe is raised.
- R3: When req_n is low while ack_n is high, and the engine is not waiting on a handler, ack_n goes low on the next edge. In the same cycle byte_done pulses for one cycle, provided the direction is correct.
- R4: While collecting a command code or arguments, host_to_dev must be 1. While returning a response it must be 0. On a mismatch ack_n still goes low and dir_err pulses instead of byte_done, and no byte is consumed or produced.
- R5: The byte received in the idle phase is the command code. Table entries: 0x10 takes 2 arguments and returns 1 byte (handled). 0x20 takes a variable count and returns a variable size (handled). 0x38 takes 0 arguments and returns 3 bytes (no handler). 0x40 takes 1 argument and returns 0 bytes (handled). Every other code takes 0 arguments and returns a variable size (no handler).
- R6: For a variable argument length, the first byte after the command code is the argument count, and it is not stored.
- R7: When the number of argument bytes received equals the argument length, a handled command raises disp_start for exactly one cycle, with disp_cmd and disp_nargs valid. No further request is served until disp_done.
- R8: A fixed response length sends exactly that many bytes from the response buffer, in index order. A variable response first sends the size given with disp_done (capped at the buffer depth), then that many bytes.
- R9: The engine returns to idle as soon as the sent count equals the response length. This includes zero-length responses, which end right at dispatch or right after a size byte of 0.
- R10: A command without a handler returns zero bytes for a fixed length, or a single size byte of 0 for a variable length.
- R11: Argument bytes beyond the buffer depth (32) are dropped rather than stored. They are still counted toward completion and reported in disp_nargs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | 1 | Host byte request, active low |
| host_to_dev | input | 1 | 1: host sends the byte, 0: device sends it |
| rx_byte | input | 8 | Byte offered by the host |
| ack_n | output | 1 | Device acknowledge, active low |
| tx_byte | output | 8 | Byte returned to the host, valid from byte_done |
| byte_done | output | 1 | One-cycle strobe: a byte was consumed or produced |
| dir_err | output | 1 | One-cycle strobe: request with the wrong direction |
| disp_start | output | 1 | One-cycle handler start |
| disp_cmd | output | 8 | Command code for the handler |
| disp_nargs | output | 8 | Argument bytes received |
| disp_done | input | 1 | Handler completion pulse |
| disp_size | input | 8 | Response size given with disp_done |
| arg_raddr | input | 5 | Argument buffer read address |
| arg_rdata | output | 8 | Argument buffer read data |
| rsp_we | input | 1 | Response buffer write enable |
| rsp_waddr | input | 5 | Response buffer write address |
| rsp_wdata | input | 8 | Response buffer write data |

## Verification
The framer is driven with command shapes that exercise different parts of the length logic:
- A fixed-in/fixed-out command shows that the table counts govern both phases.
- A variable-in/variable-out command shows the count byte and the size byte being handled.
- A variable command with a zero count shows completion in the same event.
- A fixed zero-response command shows the return to idle at dispatch.
- Handler-less fixed and variable codes tell the two zero-fill forms apart.

Wrong-direction requests, both in idle and in the middle of a response, show that no byte and no position is consumed. A 34-byte argument stream tells dropping apart from wrap-around overwriting.

// File: rtl/cmd_link_pkg.sv
package cmd_link_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_WAIT = 2'd2,
        ST_RSP  = 2'd3
    } link_state_e;

    // one length-table entry
    typedef struct packed {
        logic       arg_var;
        logic [7:0] arg_len;
        logic       rsp_var;
        logic [7:0] rsp_len;
        logic       handled;
    } cmd_desc_t;

    // engine registers
    typedef struct packed {
        link_state_e state;
        logic        ack_n;
        logic        done;
        logic        err;
        logic        start;
        logic [7:0]  tx;
        logic [7:0]  cmd;
        logic        handled;
        logic        len_known;
        logic [7:0]  arg_len;
        logic [7:0]  rx_cnt;
        logic        rsp_known;
        logic [7:0]  rsp_len;
        logic [7:0]  tx_cnt;
        logic        zero_fill;
    } link_regs_t;

    localparam logic [7:0] CODE_PAIR  = 8'h10;
    localparam logic [7:0] CODE_BLOCK = 8'h20;
    localparam logic [7:0] CODE_ZERO3 = 8'h38;
    localparam logic [7:0] CODE_POKE  = 8'h40;

endpackage

// File: rtl/cmd_len_table.sv
module cmd_len_table
    import cmd_link_pkg::*;
(
    input  logic [7:0] code,
    output cmd_desc_t  desc
);
    always_comb begin
        unique case (code)
            CODE_PAIR:  desc = '{arg_var: 1'b0, arg_len: 8'd2, rsp_var: 1'b0, rsp_len: 8'd1, handled: 1'b1};
            CODE_BLOCK: desc = '{arg_var: 1'b1, arg_len: 8'd0, rsp_var: 1'b1, rsp_len: 8'd0, handled: 1'b1};
            CODE_ZERO3: desc = '{arg_var: 1'b0, arg_len: 8'd0, rsp_var: 1'b0, rsp_len: 8'd3, handled: 1'b0};
            CODE_POKE:  desc = '{arg_var: 1'b0, arg_len: 8'd1, rsp_var: 1'b0, rsp_len: 8'd0, handled: 1'b1};
            default:    desc = '{arg_var: 1'b0, arg_len: 8'd0, rsp_var: 1'b1, rsp_len: 8'd0, handled: 1'b0};
        endcase
    end
endmodule

// File: rtl/byte_store.sv
module byte_store #(
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cmd_link_framer.sv
module cmd_link_framer
    import cmd_link_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_n,
    input  logic          host_to_dev,
    input  logic [7:0]    rx_byte,
    output logic          ack_n,
    output logic [7:0]    tx_byte,
    output logic          byte_done,
    output logic          dir_err,
    output logic          disp_start,
    output logic [7:0]    disp_cmd,
    output logic [7:0]    disp_nargs,
    input  logic          disp_done,
    input  logic [7:0]    disp_size,
    input  logic [AW-1:0] arg_raddr,
    output logic [7:0]    arg_rdata,
    input  logic          rsp_we,
    input  logic [AW-1:0] rsp_waddr,
    input  logic [7:0]    rsp_wdata
);
    localparam logic [7:0] DEPTH_B = 8'(DEPTH);

    link_regs_t  q, d;
    cmd_desc_t   desc;
    logic        arg_we;
    logic [7:0]  rsp_rdata;
    link_state_e cur_state;

    cmd_len_table u_table (
        .code (rx_byte),
        .desc (desc)
    );

    byte_store #(.DEPTH(DEPTH)) u_args (
        .clk   (clk),
        .we    (arg_we),
        .waddr (q.rx_cnt[AW-1:0]),
        .wdata (rx_byte),
        .raddr (arg_raddr),
        .rdata (arg_rdata)
    );

    byte_store #(.DEPTH(DEPTH)) u_rsp (
        .clk   (clk),
        .we    (rsp_we),
        .waddr (rsp_waddr),
        .wdata (rsp_wdata),
        .raddr (q.tx_cnt[AW-1:0]),
        .rdata (rsp_rdata)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        d.start  = 1'b0;
        arg_we   = 1'b0;

        if (req_n && !q.ack_n) begin
            // host released its request: release acknowledge
            d.ack_n = 1'b1;
        end else if (!req_n && q.ack_n && q.state != ST_WAIT) begin
            d.ack_n = 1'b0;
            if (host_to_dev != (q.state != ST_RSP)) begin
                d.err = 1'b1;
            end else begin
                d.done = 1'b1;
                unique case (q.state)
                    ST_IDLE: begin
                        d.cmd       = rx_byte;
                        d.handled   = desc.handled;
                        d.len_known = !desc.arg_var;
                        d.arg_len   = desc.arg_len;
                        d.rsp_known = !desc.rsp_var;
                        d.rsp_len   = desc.rsp_len;
                        d.rx_cnt    = '0;
                        d.tx_cnt    = '0;
                        d.zero_fill = 1'b0;
                        d.state     = ST_CMD;
                    end
                    ST_CMD: begin
                        if (!q.len_known) begin
                            d.arg_len   = rx_byte;
                            d.len_known = 1'b1;
                        end else begin
                            arg_we   = (q.rx_cnt < DEPTH_B);
                            d.rx_cnt = q.rx_cnt + 8'd1;
                        end
                    end
                    ST_RSP: begin
                        if (!q.rsp_known) begin
                            d.tx        = q.rsp_len;
                            d.rsp_known = 1'b1;
                        end else begin
                            d.tx     = q.zero_fill ? 8'h00 : rsp_rdata;
                            d.tx_cnt = q.tx_cnt + 8'd1;
                        end
                    end
                    default: ;
                endcase

                // argument phase complete
                if (d.state == ST_CMD && d.len_known && d.rx_cnt == d.arg_len) begin
                    if (d.handled) begin
                        d.start = 1'b1;
                        d.state = ST_WAIT;
                    end else begin
                        d.zero_fill = 1'b1;
                        d.state     = ST_RSP;
                    end
                end
                // response phase complete (may follow in the same event)
                if (d.state == ST_RSP && d.rsp_known && d.tx_cnt == d.rsp_len) begin
                    d.state = ST_IDLE;
                end
            end
        end

        if (q.state == ST_WAIT && disp_done) begin
            if (!q.rsp_known) begin
                d.rsp_len = (disp_size > DEPTH_B) ? DEPTH_B : disp_size;
            end
            d.state = (q.rsp_known && q.rsp_len == 8'd0) ? ST_IDLE : ST_RSP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q           <= '0;
            q.state     <= ST_IDLE;
            q.ack_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cur_state  = q.state;
    assign ack_n      = q.ack_n;
    assign tx_byte    = q.tx;
    assign byte_done  = q.done;
    assign dir_err    = q.err;
    assign disp_start = q.start;
    assign disp_cmd   = q.cmd;
    assign disp_nargs = q.rx_cnt;
endmodule

// File: rtl/cmd_link_framer_chk.sv
module cmd_link_framer_chk
    import cmd_link_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_n,
    input logic        ack_n,
    input logic        byte_done,
    input logic        dir_err,
    input logic        disp_start,
    input logic        disp_done,
    input link_state_e cur_state
);
    a_r2_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && req_n) |=> ack_n);

    a_r3_done_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $fell(ack_n));

    a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> $past(!req_n));

    a_r4_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        dir_err |-> (!byte_done && $fell(ack_n)));

    a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        disp_start |=> !disp_start);

    a_r7_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_WAIT && !disp_done) |=> !byte_done);
endmodule

bind cmd_link_framer cmd_link_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n      (req_n),
    .ack_n      (ack_n),
    .byte_done  (byte_done),
    .dir_err    (dir_err),
    .disp_start (disp_start),
    .disp_done  (disp_done),
    .cur_state  (cur_state)
);

// File: tb/cmd_link_framer_test.sv
module cmd_link_framer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_n = 1'b1;
    logic       host_to_dev = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic       ack_n, byte_done, dir_err, disp_start;
    logic [7:0] tx_byte, disp_cmd, disp_nargs;
    logic       disp_done = 1'b0;
    logic [7:0] disp_size = 8'h00;
    logic [4:0] arg_raddr = '0;
    logic [7:0] arg_rdata;
    logic       rsp_we = 1'b0;
    logic [4:0] rsp_waddr = '0;
    logic [7:0] rsp_wdata = 8'h00;

    int checks = 0;
    int errors = 0;
    logic [7:0] last_nargs = 8'h00;

    always #2.5 clk = ~clk;

    cmd_link_framer uut (.*);

    typedef struct packed {
        logic [7:0]  cmd;
        logic [3:0]  n_in;
        logic [47:0] din;
        logic [3:0]  n_out;
        logic [47:0] dout;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 4'd2, 48'h0000_0000_0705, 4'd1, 48'h0000_0000_000C},  // R5 R8 fixed
        '{8'h20, 4'd4, 48'h0000_CCBB_AA03, 4'd4, 48'h0000_CCBB_AA03},  // R6 R8 variable
        '{8'h20, 4'd1, 48'h0000_0000_0000, 4'd1, 48'h0000_0000_0000},  // R9 zero count
        '{8'h38, 4'd0, 48'h0,              4'd3, 48'h0},               // R10 zero fill
        '{8'h55, 4'd0, 48'h0,              4'd1, 48'h0},               // R10 empty
        '{8'h40, 4'd1, 48'h0000_0000_0009, 4'd0, 48'h0}                // R9 zero-length
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one host transaction; returns strobes and the byte seen
    task automatic xfer(input logic dir, input logic [7:0] b,
                        output logic got_done, output logic got_err, output logic [7:0] got);
        @(negedge clk);
        host_to_dev = dir;
        rx_byte = b;
        req_n = 1'b0;
        @(negedge clk);
        while (ack_n) @(negedge clk);
        got_done = byte_done;
        got_err  = dir_err;
        got      = tx_byte;
        req_n = 1'b1;
        @(negedge clk);
        check("R2 ack release", int'(ack_n), 1);
    endtask

    task automatic send(input logic [7:0] b, input string tag);
        logic dn, er;
        logic [7:0] g;
        xfer(1'b1, b, dn, er, g);
        check({tag, " R3 byte_done on send"}, int'(dn), 1);
    endtask

    task automatic recv_exp(input logic [7:0] exp, input string tag);
        logic dn, er;
        logic [7:0] g;
        xfer(1'b0, 8'h00, dn, er, g);
        check({tag, " R3 byte_done on recv"}, int'(dn), 1);
        check({tag, " R8 data"}, int'(g), int'(exp));
    endtask

    // external handler model
    initial begin
        forever begin
            @(negedge clk);
            if (disp_start) begin
                automatic logic [7:0] c = disp_cmd;
                automatic logic [7:0] n = disp_nargs;
                automatic logic [7:0] sz = 8'd0;
                last_nargs = n;
                if (c == 8'h10) begin
                    arg_raddr = 5'd0; #1;
                    rsp_wdata = arg_rdata;
                    arg_raddr = 5'd1; #1;
                    rsp_wdata = rsp_wdata + arg_rdata;
                    rsp_waddr = 5'd0; rsp_we = 1'b1;
                    @(negedge clk);
                    rsp_we = 1'b0;
                    sz = 8'd1;
                end else if (c == 8'h20) begin
                    sz = (n > 8'd32) ? 8'd32 : n;
                    for (int k = 0; k < int'(sz); k++) begin
                        arg_raddr = 5'(k); #1;
                        rsp_wdata = arg_rdata;
                        rsp_waddr = 5'(k);
                        rsp_we = 1'b1;
                        @(negedge clk);
                    end
                    rsp_we = 1'b0;
                end
                disp_size = sz;
                disp_done = 1'b1;
                @(negedge clk);
                disp_done = 1'b0;
            end
        end
    end

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R3 actual=hang expected=completion");
        finish_run();
    end

    initial begin
        logic dn, er;
        logic [7:0] g;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 ack_n", int'(ack_n), 1);
        check("R1 byte_done", int'(byte_done), 0);
        check("R1 dir_err", int'(dir_err), 0);
        check("R1 disp_start", int'(disp_start), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table-driven commands
        for (int v = 0; v < NV; v++) begin
            send(VECS[v].cmd, "R5 cmd");
            for (int i = 0; i < int'(VECS[v].n_in); i++)
                send(VECS[v].din[8*i +: 8], "R6 arg");
            for (int i = 0; i < int'(VECS[v].n_out); i++)
                recv_exp(VECS[v].dout[8*i +: 8], "R10 vec");
        end

        // R4: wrong direction in idle, offered byte must not become the command
        xfer(1'b0, 8'h10, dn, er, g);
        check("R4 idle err", int'(er), 1);
        check("R4 idle no done", int'(dn), 0);
        send(8'h38, "R4 follow");
        for (int i = 0; i < 3; i++) recv_exp(8'h00, "R10 zero3");

        // R4: wrong direction mid-response must not advance the position
        send(8'h38, "R4 rsp");
        recv_exp(8'h00, "R4 rsp0");
        xfer(1'b1, 8'h77, dn, er, g);
        check("R4 rsp err", int'(er), 1);
        check("R4 rsp no done", int'(dn), 0);
        recv_exp(8'h00, "R4 rsp1");
        recv_exp(8'h00, "R4 rsp2");
        // R9: engine back in idle accepts a new code
        send(8'h55, "R9 next");
        recv_exp(8'h00, "R9 size0");

        // R11: 34 arguments, the last two dropped
        send(8'h20, "R11 cmd");
        send(8'd34, "R11 count");
        for (int i = 0; i < 34; i++) send(8'(i + 1), "R11 arg");
        recv_exp(8'd32, "R11 size");
        check("R11 nargs", int'(last_nargs), 34);
        for (int i = 0; i < 32; i++) recv_exp(8'(i + 1), "R11 data");

        // R7: handler still sees a fixed command after overflow
        send(8'h10, "R7 cmd");
        send(8'h20, "R7 a0");
        send(8'h01, "R7 a1");
        recv_exp(8'h21, "R7 sum");
        check("R7 nargs", int'(last_nargs), 2);

        finish_run();
    end
endmodule